// File: doc/BRIEF.md
# Two-Way Tag Cache with Run-Time Replacement Choice

This block is a tag-only model of a small two-way set-associative cache. A requester presents one block address per accepted cycle. One cycle later the block answers with a hit flag. When a miss forces a resident block out, it also flags the eviction and gives the address of the block that left. No data is stored, and there is no write policy and no refill path. The block tracks only which block addresses are resident, together with the recency of each set.

Every request carries a two-bit policy code. The victim choice can therefore move between least recently used, most recently used and pseudo-random without disturbing the tag contents. The random choice is taken from a free-running shift register. A saturating counter totals the hits since the last reset. The block fits replacement studies and trace-driven checks of the hit rates of different policies on one address stream.

Top module: `assoc_tag_cache`

## Requirements
- R1: An access is accepted when `req_valid` and `req_ready` are both high at a rising clock edge. Exactly one cycle later `resp_valid` is high for one cycle, and `resp_hit` is 1 when the addressed block was resident.
- R2: The set index is the low `$clog2(NUM_SETS)` bits of the block address, and the tag is the remaining upper bits. An evicted block always belongs to the set of the request that displaced it.
- R3: A miss in a set that still has an empty way fills that way, way 0 before way 1, and reports `resp_evict_valid` = 0.
- R4: Policy code 0 (LRU): a miss in a full set evicts the way that was touched less recently.
- R5: Policy code 1 (MRU): a miss in a full set evicts the way that was touched most recently.
- R6: Policy code 2 (random): a miss in a full set evicts way 0 when the current shift-register bit is 0 and way 1 when it is 1. The victim is always one of the two resident blocks, and the new block is resident afterwards.
- R7: Policy code 3 acts as LRU. The code is sampled with each request, so the policy can change between any two accesses over the same contents.
- R8: On an eviction, `resp_evict_addr` is the full block address of the block removed. A hit never reports an eviction.
- R9: `hit_count` rises by one with each hit response and saturates at all ones. It is unchanged on misses and on idle cycles.
- R10: Reset clears all valid bits, the recency bits and `hit_count`, and reloads the shift-register seed. `req_ready` is low during reset and high afterwards.
- R11: Every hit and every fill marks the way it touched as the most recent way of its set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pol_sel | input | 2 | Replacement code: 0 LRU, 1 MRU, 2 random, 3 LRU |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | ADDR_W | Block address of the access |
| resp_valid | output | 1 | Response for the access accepted in the previous cycle |
| resp_hit | output | 1 | Access hit |
| resp_evict_valid | output | 1 | A resident block was evicted |
| resp_evict_addr | output | ADDR_W | Address of the evicted block |
| hit_count | output | HIT_CNT_W | Saturating total of hits |

## Verification
The hardest case to reach is a policy change that lands on a full set. Only the recency bit left by earlier accesses separates an LRU eviction from an MRU eviction. The stimulus therefore fills a set under one code, touches one way so that its recency is known, and then issues the conflicting miss under the other code. The reserved code gets the same treatment. Random eviction cannot be predicted from the ports, so each random miss is checked for a victim that is one of the two blocks the bench's own model holds, and the new block is then checked to hit.

// File: rtl/assoc_tag_cache_pkg.sv
package assoc_tag_cache_pkg;
   typedef enum logic [1:0] {
      REPL_LRU  = 2'd0,
      REPL_MRU  = 2'd1,
      REPL_RAND = 2'd2,
      REPL_ALT  = 2'd3
   } repl_code_e;

   localparam int unsigned WAYS = 2;
endpackage

// File: rtl/atc_lfsr.sv
module atc_lfsr #(
   parameter int unsigned          W     = 16,
   parameter logic [W-1:0]         SEED  = 16'hACE1,
   parameter logic [W-1:0]         TAPS  = 16'hB400
) (
   input  logic clk,
   input  logic rst_n,
   output logic rnd_bit
);
   generate
      if (SEED == '0) begin : g_bad_seed
         $error("atc_lfsr: SEED must be nonzero");
      end
   endgenerate

   logic [W-1:0] state_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SEED;
      else        state_q <= {1'b0, state_q[W-1:1]} ^ (state_q[0] ? TAPS : '0);
   end

   assign rnd_bit = state_q[0];
endmodule

// File: rtl/atc_set_array.sv
module atc_set_array #(
   parameter int unsigned NUM_SETS = 2,
   parameter int unsigned TAG_W    = 7,
   localparam int unsigned IDX_W   = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] rd_idx,
   output logic [1:0]       rd_valid,
   output logic [TAG_W-1:0] rd_tag0,
   output logic [TAG_W-1:0] rd_tag1,
   output logic             rd_recent,
   input  logic             upd_en,
   input  logic [IDX_W-1:0] upd_idx,
   input  logic             upd_way,
   input  logic             upd_fill,
   input  logic [TAG_W-1:0] upd_tag
);
   logic [NUM_SETS-1:0][1:0]       valid_q;
   logic [NUM_SETS-1:0][TAG_W-1:0] tag0_q;
   logic [NUM_SETS-1:0][TAG_W-1:0] tag1_q;
   logic [NUM_SETS-1:0]            recent_q;

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
      logic sel;
      assign sel = upd_en && (upd_idx == IDX_W'(s));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            valid_q[s]  <= '0;
            recent_q[s] <= 1'b0;
         end else if (sel) begin
            recent_q[s] <= upd_way;
            if (upd_fill) valid_q[s][upd_way] <= 1'b1;
         end
      end

      always_ff @(posedge clk) begin
         if (sel && upd_fill) begin
            if (upd_way) tag1_q[s] <= upd_tag;
            else         tag0_q[s] <= upd_tag;
         end
      end
   end

   assign rd_valid  = valid_q[rd_idx];
   assign rd_tag0   = tag0_q[rd_idx];
   assign rd_tag1   = tag1_q[rd_idx];
   assign rd_recent = recent_q[rd_idx];
endmodule

// File: rtl/atc_victim_pick.sv
module atc_victim_pick
   import assoc_tag_cache_pkg::*;
(
   input  logic [1:0] way_valid,
   input  logic       recent_way,
   input  logic [1:0] pol_code,
   input  logic       rnd_bit,
   output logic       fill_way,
   output logic       must_evict
);
   repl_code_e code;
   assign code = repl_code_e'(pol_code);

   always_comb begin
      must_evict = 1'b0;
      fill_way   = 1'b0;
      if (!way_valid[0]) begin
         fill_way = 1'b0;
      end else if (!way_valid[1]) begin
         fill_way = 1'b1;
      end else begin
         must_evict = 1'b1;
         unique case (code)
            REPL_MRU:  fill_way = recent_way;
            REPL_RAND: fill_way = rnd_bit;
            default:   fill_way = ~recent_way;
         endcase
      end
   end
endmodule

// File: rtl/assoc_tag_cache.sv
module assoc_tag_cache
   import assoc_tag_cache_pkg::*;
#(
   parameter int unsigned   ADDR_W    = 8,
   parameter int unsigned   NUM_SETS  = 2,
   parameter int unsigned   HIT_CNT_W = 16,
   parameter int unsigned   RND_W     = 16,
   parameter logic [15:0]   RND_SEED  = 16'hACE1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        pol_sel,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic              resp_evict_valid,
   output logic [ADDR_W-1:0] resp_evict_addr,
   output logic [HIT_CNT_W-1:0] hit_count
);
   localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;
   localparam int unsigned TAG_W = ADDR_W - IDX_W;

   generate
      if (NUM_SETS < 2 || (1 << IDX_W) != NUM_SETS) begin : g_bad_sets
         $error("assoc_tag_cache: NUM_SETS must be a power of two, at least 2");
      end
      if (ADDR_W <= IDX_W) begin : g_bad_addr
         $error("assoc_tag_cache: ADDR_W must exceed the index width");
      end
      if (HIT_CNT_W < 1 || RND_W != 16) begin : g_bad_misc
         $error("assoc_tag_cache: HIT_CNT_W >= 1 and RND_W == 16 required");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic [TAG_W-1:0] tag;
   assign idx = req_addr[IDX_W-1:0];
   assign tag = req_addr[ADDR_W-1:IDX_W];

   logic             accept;
   logic [1:0]       way_valid;
   logic [TAG_W-1:0] tag0, tag1;
   logic             recent_way;
   logic             rnd_bit;
   logic             hit0, hit1, hit;
   logic             fill_way, must_evict, touch_way;

   assign accept = req_valid && req_ready;

   atc_lfsr #(.W(RND_W), .SEED(RND_SEED), .TAPS(16'hB400)) u_rnd (
      .clk(clk), .rst_n(rst_n), .rnd_bit(rnd_bit)
   );

   atc_set_array #(.NUM_SETS(NUM_SETS), .TAG_W(TAG_W)) u_sets (
      .clk(clk), .rst_n(rst_n),
      .rd_idx(idx), .rd_valid(way_valid), .rd_tag0(tag0), .rd_tag1(tag1),
      .rd_recent(recent_way),
      .upd_en(accept), .upd_idx(idx), .upd_way(touch_way),
      .upd_fill(!hit), .upd_tag(tag)
   );

   atc_victim_pick u_pick (
      .way_valid(way_valid), .recent_way(recent_way), .pol_code(pol_sel),
      .rnd_bit(rnd_bit), .fill_way(fill_way), .must_evict(must_evict)
   );

   assign hit0      = way_valid[0] && (tag0 == tag);
   assign hit1      = way_valid[1] && (tag1 == tag);
   assign hit       = hit0 || hit1;
   assign touch_way = hit ? hit1 : fill_way;

   logic [TAG_W-1:0] victim_tag;
   assign victim_tag = fill_way ? tag1 : tag0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_ready        <= 1'b0;
         resp_valid       <= 1'b0;
         resp_hit         <= 1'b0;
         resp_evict_valid <= 1'b0;
         resp_evict_addr  <= '0;
         hit_count        <= '0;
      end else begin
         req_ready  <= 1'b1;
         resp_valid <= accept;
         if (accept) begin
            resp_hit         <= hit;
            resp_evict_valid <= !hit && must_evict;
            resp_evict_addr  <= (!hit && must_evict) ? {victim_tag, idx} : '0;
            if (hit && !(&hit_count)) hit_count <= hit_count + 1'b1;
         end
      end
   end
endmodule

// File: rtl/assoc_tag_cache_chk.sv
module assoc_tag_cache_chk #(
   parameter int unsigned ADDR_W    = 8,
   parameter int unsigned NUM_SETS  = 2,
   parameter int unsigned HIT_CNT_W = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 req_valid,
   input logic                 req_ready,
   input logic [ADDR_W-1:0]    req_addr,
   input logic                 resp_valid,
   input logic                 resp_hit,
   input logic                 resp_evict_valid,
   input logic [ADDR_W-1:0]    resp_evict_addr,
   input logic [HIT_CNT_W-1:0] hit_count
);
   localparam int unsigned IDX_W = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1;

   a_r1_resp_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> resp_valid);

   a_r1_resp_needs_accept: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> $past(req_valid && req_ready));

   a_r8_hit_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit) |-> !resp_evict_valid);

   a_r2_evict_same_set: assert property (@(posedge clk) disable iff (!rst_n)
      resp_evict_valid |-> (resp_evict_addr[IDX_W-1:0] == $past(req_addr[IDX_W-1:0])));

   a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (resp_valid && resp_hit && !(&$past(hit_count)))
         |-> (hit_count == $past(hit_count) + 1'b1));

   a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(resp_valid && resp_hit) |-> $stable(hit_count));
endmodule

bind assoc_tag_cache assoc_tag_cache_chk #(
   .ADDR_W(ADDR_W), .NUM_SETS(NUM_SETS), .HIT_CNT_W(HIT_CNT_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_addr(req_addr), .resp_valid(resp_valid), .resp_hit(resp_hit),
   .resp_evict_valid(resp_evict_valid), .resp_evict_addr(resp_evict_addr),
   .hit_count(hit_count)
);

// File: tb/assoc_tag_cache_tb_top.sv
module assoc_tag_cache_tb_top;
   localparam int CW = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] pol_sel = 2'd0;
   logic       req_valid = 1'b0;
   logic       req_ready;
   logic [7:0] req_addr = 8'd0;
   logic       resp_valid, resp_hit, resp_evict_valid;
   logic [7:0] resp_evict_addr;
   logic [CW-1:0] hit_count;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   assoc_tag_cache #(.ADDR_W(8), .NUM_SETS(2), .HIT_CNT_W(CW)) dut_i (
      .clk(clk), .rst_n(rst_n), .pol_sel(pol_sel), .req_valid(req_valid),
      .req_ready(req_ready), .req_addr(req_addr), .resp_valid(resp_valid),
      .resp_hit(resp_hit), .resp_evict_valid(resp_evict_valid),
      .resp_evict_addr(resp_evict_addr), .hit_count(hit_count)
   );

   // {reset_before, policy, addr, hit, evict_valid, evict_addr, count_after}
   localparam int NV = 24;
   localparam logic [24:0] VEC [NV] = '{
      // LRU run (R4, R3, R11)
      {1'b1, 2'd0, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0},
      {1'b0, 2'd0, 8'd2, 1'b0, 1'b0, 8'd0, 4'd0},
      {1'b0, 2'd0, 8'd0, 1'b1, 1'b0, 8'd0, 4'd1},
      {1'b0, 2'd0, 8'd4, 1'b0, 1'b1, 8'd2, 4'd1},
      {1'b0, 2'd0, 8'd2, 1'b0, 1'b1, 8'd0, 4'd1},
      {1'b0, 2'd0, 8'd4, 1'b1, 1'b0, 8'd0, 4'd2},
      {1'b0, 2'd0, 8'd1, 1'b0, 1'b0, 8'd0, 4'd2},
      {1'b0, 2'd0, 8'd3, 1'b0, 1'b0, 8'd0, 4'd2},
      {1'b0, 2'd0, 8'd5, 1'b0, 1'b1, 8'd1, 4'd2},
      {1'b0, 2'd0, 8'd3, 1'b1, 1'b0, 8'd0, 4'd3},
      {1'b0, 2'd0, 8'd4, 1'b1, 1'b0, 8'd0, 4'd4},
      {1'b0, 2'd0, 8'd2, 1'b1, 1'b0, 8'd0, 4'd5},
      // MRU run (R5)
      {1'b1, 2'd1, 8'd0, 1'b0, 1'b0, 8'd0, 4'd0},
      {1'b0, 2'd1, 8'd2, 1'b0, 1'b0, 8'd0, 4'd0},
      {1'b0, 2'd1, 8'd4, 1'b0, 1'b1, 8'd2, 4'd0},
      {1'b0, 2'd1, 8'd0, 1'b1, 1'b0, 8'd0, 4'd1},
      {1'b0, 2'd1, 8'd6, 1'b0, 1'b1, 8'd0, 4'd1},
      {1'b0, 2'd1, 8'd4, 1'b1, 1'b0, 8'd0, 4'd2},
      {1'b0, 2'd1, 8'd8, 1'b0, 1'b1, 8'd4, 4'd2},
      {1'b0, 2'd1, 8'd6, 1'b1, 1'b0, 8'd0, 4'd3},
      {1'b0, 2'd1, 8'd1, 1'b0, 1'b0, 8'd0, 4'd3},
      {1'b0, 2'd1, 8'd1, 1'b1, 1'b0, 8'd0, 4'd4},
      {1'b0, 2'd1, 8'd3, 1'b0, 1'b0, 8'd0, 4'd4},
      {1'b0, 2'd1, 8'd5, 1'b0, 1'b1, 8'd3, 4'd4}
   };

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      req_valid = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic access(input logic [1:0] pol, input logic [7:0] a);
      @(negedge clk);
      pol_sel = pol;
      req_addr = a;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not complete");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0] way_a, way_b, nb;
      // R10: state during and after reset
      @(negedge clk);
      check(req_ready == 1'b0, "R10", "ready in reset", req_ready, 0);
      check(resp_valid == 1'b0, "R10", "resp_valid in reset", resp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(req_ready == 1'b1, "R10", "ready after reset", req_ready, 1);
      check(hit_count == 0, "R10", "count after reset", hit_count, 0);

      // Vector walk: R1 R2 R3 R4 R5 R8 R9 R11
      for (int i = 0; i < NV; i++) begin
         if (VEC[i][24]) do_reset();
         access(VEC[i][23:22], VEC[i][21:14]);
         check(resp_valid == 1'b1, "R1", $sformatf("vec %0d resp_valid", i), resp_valid, 1);
         check(resp_hit == VEC[i][13], "R1", $sformatf("vec %0d hit", i), resp_hit, VEC[i][13]);
         check(resp_evict_valid == VEC[i][12], "R4/R5", $sformatf("vec %0d evict", i),
               resp_evict_valid, VEC[i][12]);
         if (VEC[i][12])
            check(resp_evict_addr == VEC[i][11:4], "R8", $sformatf("vec %0d victim", i),
                  resp_evict_addr, VEC[i][11:4]);
         check(hit_count == VEC[i][3:0], "R9", $sformatf("vec %0d count", i),
               hit_count, VEC[i][3:0]);
      end
      @(negedge clk);
      check(resp_valid == 1'b0, "R1", "resp single cycle", resp_valid, 0);

      // R10: reset clears valid bits (block 1 was resident)
      do_reset();
      access(2'd0, 8'd1);
      check(resp_hit == 1'b0, "R10", "miss after reset", resp_hit, 0);
      check(resp_evict_valid == 1'b0, "R3", "empty way fill", resp_evict_valid, 0);

      // R7: policy switch on the same contents
      do_reset();
      access(2'd0, 8'd0);
      access(2'd0, 8'd2);
      access(2'd0, 8'd0);
      access(2'd1, 8'd4);
      check(resp_evict_valid && resp_evict_addr == 8'd0, "R7", "switch to MRU victim",
            resp_evict_addr, 0);
      access(2'd0, 8'd6);
      check(resp_evict_valid && resp_evict_addr == 8'd2, "R7", "switch back to LRU victim",
            resp_evict_addr, 2);

      // R7: code 3 behaves as LRU
      do_reset();
      access(2'd3, 8'd1);
      access(2'd3, 8'd3);
      access(2'd3, 8'd1);
      access(2'd3, 8'd5);
      check(resp_evict_valid && resp_evict_addr == 8'd3, "R7", "code 3 victim",
            resp_evict_addr, 3);

      // R6: random victims stay inside the resident pair
      do_reset();
      access(2'd2, 8'd0);
      access(2'd2, 8'd2);
      way_a = 8'd0;
      way_b = 8'd2;
      for (int k = 0; k < 8; k++) begin
         nb = 8'(10 + 2 * k);
         access(2'd2, nb);
         check(resp_evict_valid == 1'b1, "R6", "random evict flag", resp_evict_valid, 1);
         check(resp_evict_addr == way_a || resp_evict_addr == way_b, "R6",
               "random victim resident", resp_evict_addr, way_a);
         if (resp_evict_addr == way_a) way_a = nb;
         else                          way_b = nb;
         access(2'd2, nb);
         check(resp_hit == 1'b1, "R6", "new block resident", resp_hit, 1);
      end

      // R9: saturation of the hit counter
      do_reset();
      access(2'd0, 8'd7);
      for (int k = 0; k < 17; k++) access(2'd0, 8'd7);
      check(hit_count == 4'hF, "R9", "count saturates", hit_count, 15);
      check(resp_hit == 1'b1, "R9", "hit at saturation", resp_hit, 1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule